// File: doc/BRIEF.md
# Key-Protected Slow Clock Selector

This block produces the always-on low-speed clock of a chip. It runs on the fast internal RC oscillator, which serves as both the register clock and the counting clock. It offers two sources. One is that oscillator divided by a fixed power-of-two predivider and then by a programmable factor N+1. The other is an external 32.768 kHz crystal input, which arrives asynchronously and is brought into the domain by a two-flop synchronizer. A switching state machine changes source without cutting a high phase short. A gate then decides whether the selected clock also reaches an output pin.

Software reaches three registers through a simple write-strobe and read-mux interface. The control register is guarded by an unlock key: a write changes it only when the upper half of the write data carries the key. When the external source is selected, a synchronized failure input makes the output fall back to the internal path. A bypass bit in the control register can suppress that fallback.

The switching machine has six states:
- INT_RUN: the output follows the internal phase.
- INT_DRAIN: the output still follows the internal phase until that phase is low.
- EXT_WAIT: the output is held low until the synchronized crystal is low.
- EXT_RUN: the output follows the crystal.
- EXT_DRAIN: the output still follows the crystal until it is low.
- INT_WAIT: the output is held low until the internal phase is low.

Its transitions are:
- INT_RUN to INT_DRAIN when the external source becomes wanted.
- INT_DRAIN to EXT_WAIT when the internal phase is low.
- EXT_WAIT to EXT_RUN when the crystal is low.
- EXT_RUN to EXT_DRAIN when the external source is no longer wanted (deselected, or failed without bypass).
- EXT_DRAIN to INT_WAIT when the crystal is low.
- INT_WAIT to INT_RUN when the internal phase is low.

Top module: `lsclk_select`

## Requirements
- R1: During and after reset the control, divider and gate registers read 0, the internal path is selected with N=0, and both clock outputs are low while reset is held.
- R2: A write to offset 0x00 updates the control register only when write-data bits 31:16 equal 0x16AA; with any other value in those bits the register keeps its contents.
- R3: The control register stores bit 0 (source select), bit 4 (crystal enable) and bit 15 (fallback bypass); reads return every other bit, including 31:16, as 0. The gate register at offset 0x60 holds bit 0 only. Unmapped offsets read 0.
- R4: With the internal source selected, the slow clock period is PREDIV*(N+1) register-clock cycles, and the clock is high for exactly half of that period.
- R5: The divider register at offset 0x08 keeps write-data bits 4:0 as N, reads back only those bits, and needs no key.
- R6: With control bit 0 set, the slow clock has the period and high time of the external input.
- R7: On any source change the output is held low while waiting, and no high phase is shorter than the shorter of the two sources' high phases.
- R8: While the external source is selected, a high failure input returns the output to the internal path when bit 15 is 0 and leaves it on the crystal when bit 15 is 1; in neither case is the control register changed.
- R9: The pin clock equals the slow clock when gate bit 0 is 1 and stays low when it is 0; a gate change never alters the pin inside a high phase.
- R10: The crystal-enable output follows control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal RC oscillator; register and counting clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| xtal_clk_i | input | 1 | External 32.768 kHz crystal clock, asynchronous |
| xtal_fail_i | input | 1 | External clock failure indication, asynchronous |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| slow_clk_o | output | 1 | Selected low-speed clock |
| pin_clk_o | output | 1 | Gated copy of the slow clock for the output pin |

## Verification
The embedded properties are checked on every cycle:
- a bad-key write leaves the control register untouched;
- the predivider wraps at its terminal count;
- both waiting states keep the output low;
- a failure without bypass drives the machine out of EXT_RUN;
- the pin never changes during a high phase.

The exact period and duty of every divider setting can only be shown by the bench's scenarios. The same holds for following the crystal's timing, for the minimum high pulse across a real switch, and for register readback with masked bits.

// File: rtl/skc_pkg.sv
package skc_pkg;
    localparam int KEY_W      = 16;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h16AA;
    localparam int CTL_OFS    = 'h00;
    localparam int DIV_OFS    = 'h08;
    localparam int GATE_OFS   = 'h60;
    localparam int SEL_BIT    = 0;
    localparam int XEN_BIT    = 4;
    localparam int BYP_BIT    = 15;

    typedef struct packed {
        logic byp;
        logic xen;
        logic sel;
    } ctl_t;

    typedef enum logic [2:0] {
        INT_RUN, INT_DRAIN, EXT_WAIT, EXT_RUN, EXT_DRAIN, INT_WAIT
    } sw_state_t;
endpackage

// File: rtl/skc_sync.sv
module skc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/skc_regs.sv
module skc_regs
    import skc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output ctl_t              ctl_o,
    output logic [DIV_W-1:0]  div_n_o,
    output logic              gate_o
);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(DIV_OFS);
    localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(GATE_OFS);

    ctl_t             ctl_q;
    logic [DIV_W-1:0] div_q;
    logic             gate_q;
    logic             key_ok;
    logic             unused_wdata;

    assign key_ok       = (wdata_i[DATA_W-1 -: KEY_W] == UNLOCK_KEY);
    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            div_q  <= '0;
            gate_q <= 1'b0;
        end else if (we_i) begin
            unique case (addr_i)
                A_CTL: if (key_ok) begin
                    ctl_q.sel <= wdata_i[SEL_BIT];
                    ctl_q.xen <= wdata_i[XEN_BIT];
                    ctl_q.byp <= wdata_i[BYP_BIT];
                end
                A_DIV:   div_q  <= wdata_i[DIV_W-1:0];
                A_GATE:  gate_q <= wdata_i[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CTL: begin
                rdata_o[SEL_BIT] = ctl_q.sel;
                rdata_o[XEN_BIT] = ctl_q.xen;
                rdata_o[BYP_BIT] = ctl_q.byp;
            end
            A_DIV:   rdata_o[DIV_W-1:0] = div_q;
            A_GATE:  rdata_o[0] = gate_q;
            default: ;
        endcase
    end

    assign ctl_o   = ctl_q;
    assign div_n_o = div_q;
    assign gate_o  = gate_q;

    // R2: a control write without the key must not move the register
    assert_badkey_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_CTL && !key_ok) |=> $stable(ctl_q));
endmodule

// File: rtl/skc_divider.sv
module skc_divider #(
    parameter int PREDIV = 32,
    parameter int DIV_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] n_i,
    output logic             phase_o
);
    localparam int PW    = $clog2(PREDIV);
    localparam int POS_W = DIV_W + PW + 1;

    logic [PW-1:0]    pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             tick;
    logic [POS_W-1:0] pos_w;
    logic [POS_W-1:0] half_w;
    logic             phase_q;

    assign tick   = (pre_cnt == PW'(PREDIV - 1));
    assign pos_w  = {1'b0, div_cnt, pre_cnt};
    assign half_w = ({{(PW + 1){1'b0}}, n_i} + POS_W'(1)) << (PW - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            phase_q <= 1'b0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + PW'(1);
            if (tick) div_cnt <= (div_cnt >= n_i) ? '0 : div_cnt + DIV_W'(1);
            phase_q <= (pos_w < half_w);
        end
    end

    assign phase_o = phase_q;

    // R4: the predivider returns to zero after its terminal count
    assert_prediv_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt == PW'(PREDIV - 1)) |=> (pre_cnt == '0));
endmodule

// File: rtl/skc_switch.sv
module skc_switch
    import skc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_ph_i,
    input  logic xtal_i,
    input  logic fail_i,
    input  ctl_t ctl_i,
    input  logic gate_i,
    output logic slow_o,
    output logic pin_o
);
    sw_state_t state_q, state_n;
    logic      xtal_s, fail_s, want_ext;
    logic      slow_d, slow_q, pin_q, gate_hold;

    skc_sync #(.STAGES(SYNC_STAGES)) u_xtal_sync (
        .clk(clk), .rst_n(rst_n), .d_i(xtal_i), .q_o(xtal_s));
    skc_sync #(.STAGES(SYNC_STAGES)) u_fail_sync (
        .clk(clk), .rst_n(rst_n), .d_i(fail_i), .q_o(fail_s));

    assign want_ext = ctl_i.sel && !(fail_s && !ctl_i.byp);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            INT_RUN:   if (want_ext)  state_n = INT_DRAIN;
            INT_DRAIN: if (!int_ph_i) state_n = EXT_WAIT;
            EXT_WAIT:  if (!xtal_s)   state_n = EXT_RUN;
            EXT_RUN:   if (!want_ext) state_n = EXT_DRAIN;
            EXT_DRAIN: if (!xtal_s)   state_n = INT_WAIT;
            INT_WAIT:  if (!int_ph_i) state_n = INT_RUN;
            default:                  state_n = INT_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INT_RUN;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_n)
            INT_RUN, INT_DRAIN: slow_d = int_ph_i;
            EXT_RUN, EXT_DRAIN: slow_d = xtal_s;
            default:            slow_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_q    <= 1'b0;
            pin_q     <= 1'b0;
            gate_hold <= 1'b0;
        end else begin
            slow_q    <= slow_d;
            pin_q     <= slow_d & gate_hold;
            gate_hold <= slow_d ? gate_hold : gate_i;
        end
    end

    assign slow_o = slow_q;
    assign pin_o  = pin_q;

    // R7: both waiting states keep the output low
    assert_wait_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EXT_WAIT || state_q == INT_WAIT) |-> !slow_q);

    // R8: failure without bypass leaves the crystal run state
    assert_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EXT_RUN && fail_s && !ctl_i.byp) |=> (state_q == EXT_DRAIN));

    // R9: the pin is frozen for the whole of a high phase
    assert_gate_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_q && $past(slow_q)) |-> $stable(pin_q));
endmodule

// File: rtl/lsclk_select.sv
module lsclk_select
    import skc_pkg::*;
#(
    parameter int PREDIV      = 32,
    parameter int DIV_W       = 5,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xtal_clk_i,
    input  logic              xtal_fail_i,
    output logic              xtal_en_o,
    output logic              slow_clk_o,
    output logic              pin_clk_o
);
    ctl_t             ctl;
    logic [DIV_W-1:0] div_n;
    logic             gate;
    logic             int_ph;

    skc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .ctl_o(ctl),
        .div_n_o(div_n), .gate_o(gate));

    skc_divider #(.PREDIV(PREDIV), .DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .n_i(div_n), .phase_o(int_ph));

    skc_switch #(.SYNC_STAGES(SYNC_STAGES)) u_sw (
        .clk(clk), .rst_n(rst_n), .int_ph_i(int_ph), .xtal_i(xtal_clk_i),
        .fail_i(xtal_fail_i), .ctl_i(ctl), .gate_i(gate),
        .slow_o(slow_clk_o), .pin_o(pin_clk_o));

    assign xtal_en_o = ctl.xen;
endmodule

// File: tb/lsclk_select_tb.sv
module lsclk_select_tb;
    localparam int PREDIV = 4;
    localparam int XHALF  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        xtal = 1'b0;
    logic        xfail = 1'b0;
    logic        xen, slow, pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mon_min = 1000;
    int run_len = 0;
    logic prev_slow = 1'b0;

    always #2 clk = ~clk;

    lsclk_select #(.PREDIV(PREDIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xtal_clk_i(xtal),
        .xtal_fail_i(xfail), .xtal_en_o(xen), .slow_clk_o(slow), .pin_clk_o(pin));

    initial begin
        forever begin
            repeat (XHALF) @(negedge clk);
            xtal = ~xtal;
        end
    end

    always @(negedge clk) begin
        if (slow) run_len++;
        else begin
            if (prev_slow && run_len < mon_min) mon_min = run_len;
            run_len = 0;
        end
        prev_slow = slow;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic measure(output int per, output int hi);
        logic p;
        int guard;
        p = slow; guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if ((!p && slow) || guard > 5000) break;
            p = slow;
        end
        per = 0; hi = 0;
        forever begin
            if (slow) hi++;
            per++;
            p = slow;
            @(negedge clk);
            if ((!p && slow) || per > 5000) break;
        end
    endtask

    task automatic measure2(output int per, output int hi);
        measure(per, hi);
        measure(per, hi);
    endtask

    initial begin
        logic [31:0] r;
        int per, hi, cnt;
        repeat (4) @(negedge clk);
        chk(slow == 0 && pin == 0, "R1 outputs low in reset", {slow, pin}, 0);
        rst_n = 1'b1;
        rd(8'h00, r); chk(r == 0, "R1 ctl reset", r, 0);
        rd(8'h08, r); chk(r == 0, "R1 div reset", r, 0);
        rd(8'h60, r); chk(r == 0, "R1 gate reset", r, 0);
        chk(xen == 0, "R1 crystal enable reset", xen, 0);
        measure2(per, hi); chk(per == PREDIV, "R1 internal N=0 period", per, PREDIV);
        // R2: wrong key ignored, correct key accepted
        wr(8'h00, 32'h1234_8011); rd(8'h00, r); chk(r == 0, "R2 bad key ignored", r, 0);
        measure2(per, hi); chk(per == PREDIV, "R2 still internal after bad key", per, PREDIV);
        wr(8'h16, 32'h16AA_8011); rd(8'h00, r); chk(r == 0, "R3 unmapped write no effect", r, 0);
        rd(8'h16, r); chk(r == 0, "R3 unmapped read zero", r, 0);
        wr(8'h00, 32'h16AA_FFEE); rd(8'h00, r); chk(r == 32'h8000, "R3 ctl masked bits", r, 32'h8000);
        wr(8'h00, 32'h16AA_0010); rd(8'h00, r); chk(r == 32'h10, "R2 good key", r, 32'h10);
        chk(xen == 1, "R10 crystal enable on", xen, 1);
        wr(8'h00, 32'h16AA_0000); chk(xen == 0, "R10 crystal enable off", xen, 0);
        wr(8'h08, 32'hFFFF_FFE5); rd(8'h08, r); chk(r == 5, "R5 div readback", r, 5);
        wr(8'h60, 32'hFFFF_FFFF); rd(8'h60, r); chk(r == 1, "R3 gate readback", r, 1);
        // R4/R5: sweep every divider setting
        for (int n = 0; n < 32; n++) begin
            wr(8'h08, n);
            measure2(per, hi);
            chk(per == PREDIV * (n + 1), "R4 period", per, PREDIV * (n + 1));
            chk(hi == PREDIV * (n + 1) / 2, "R4 high time", hi, PREDIV * (n + 1) / 2);
        end
        // R9: gate behaviour, N=2 gives period 12 high 6
        wr(8'h08, 2);
        repeat (30) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 120; i++) begin @(negedge clk); if (pin != slow) cnt++; end
        chk(cnt == 0, "R9 pin follows slow when gated on", cnt, 0);
        wr(8'h60, 0); repeat (30) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 120; i++) begin @(negedge clk); if (pin) cnt++; end
        chk(cnt == 0, "R9 pin low when gated off", cnt, 0);
        wr(8'h60, 1);
        // R6/R7: switch to crystal
        mon_min = 1000;
        wr(8'h00, 32'h16AA_0011);
        measure2(per, hi);
        chk(per == 2 * XHALF, "R6 crystal period", per, 2 * XHALF);
        chk(hi == XHALF, "R6 crystal high", hi, XHALF);
        chk(mon_min >= 6, "R7 no short pulse int->ext", mon_min, 6);
        // R8: failure fallback and bypass
        xfail = 1'b1;
        measure2(per, hi);
        chk(per == 12, "R8 fallback to internal", per, 12);
        rd(8'h00, r); chk(r == 32'h11, "R8 ctl unchanged on fallback", r, 32'h11);
        wr(8'h00, 32'h16AA_8011);
        measure2(per, hi);
        chk(per == 2 * XHALF, "R8 bypass keeps crystal", per, 2 * XHALF);
        xfail = 1'b0;
        // R7: back to internal
        mon_min = 1000;
        wr(8'h00, 32'h16AA_0000);
        measure2(per, hi);
        chk(per == 12 && hi == 6, "R7 internal after switch back", per, 12);
        chk(mon_min >= 6, "R7 no short pulse ext->int", mon_min, 6);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule